// File: doc/BRIEF.md
# Pulse-and-Verify Word Programmer

This controller writes a block of words into a one-time-programmable memory. It erases nothing: an unwritten cell reads as one, and a program pulse can only clear bits to zero. For each word it first reads the current contents. It refuses at once a word that would need any bit raised from zero back to one. Otherwise it applies fixed-width program pulses, and after each pulse it reads the word back. It repeats this until the read-back matches or the pulse budget for the word runs out.

Once every word has verified, the controller reads the whole block back twice, first with the supply select at its high setting and then at its low setting. Any mismatch ends the job as a failure. The controller reports the failing address, and it reports whether the failure came from programming, the high-supply pass or the low-supply pass. Source data comes through a simple combinational read port indexed by word offset.

All intervals are given in nanoseconds and converted to whole clock cycles, rounded up, from a clock-frequency parameter. The interval parameters are setup, hold, the gap before output enable, pulse width and read access. Voltage generation is not part of the block; the high-voltage enable and supply select are plain outputs.

Top module: `otp_burn_ctrl`

## Requirements
- R1: After reset, done and fail are 0. Chip enable and output enable (both active low) are 1. The high-voltage enable is 0 and the data bus is not driven.
- R2: Each word of the block is programmed with one or more pulses, each followed by a read-back. On a match the controller moves to the next word, and at the end every target location holds the source word.
- R3: A word that has not matched after MAX_PULSES pulses (default 25) stops the job. Exactly MAX_PULSES pulses were applied to it, and the job ends with done=1, fail=1, fail_addr set to that address and fail_phase=0. A word that matches on the last allowed pulse passes.
- R4: During a pulse, chip enable is 0, output enable is 1 and the high-voltage enable is 1. During a programming read, chip enable is 1, output enable is 0 and the high-voltage enable is 1. The supply select is 1 throughout programming, and the data bus is never driven while output enable is 0.
- R5: Address and data are driven and stable for at least ceil(2 µs) cycles before chip enable falls for a pulse.
- R6: Each pulse lasts ceil(50 µs) cycles, which lies between 45 µs and 55 µs.
- R7: Data stays driven for at least ceil(2 µs) cycles after a pulse ends. Output enable falls no earlier than ceil(2 µs)+ceil(2 µs) cycles after the pulse ends.
- R8: A word whose source has a 1 where the current contents hold a 0 fails with zero pulses: fail_addr is its address and fail_phase=0. A word whose zeros merely extend the existing zeros programs normally.
- R9: After the last word, every word is read with chip enable 0, output enable 0 and the high-voltage enable 0, first at supply select 1 and then at supply select 0. A mismatch gives fail=1 and fail_phase=1 (high pass) or 2 (low pass), with that address.
- R10: A job that succeeds ends with done=1 and fail=0. done, fail, fail_addr and fail_phase hold until the next accepted start, and start is ignored while a job runs.
- R11: A start with word_count=0 ends with done=1 and fail=0, and no strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a job (accepted only when idle) |
| base_addr | input | AW | First target address |
| word_count | input | AW | Number of words to write |
| src_idx | output | AW | Word offset presented to the source port |
| src_data | input | DW | Source word for src_idx, combinational |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Data to program |
| mem_wdata_oe | output | 1 | Data bus drive enable |
| mem_rdata | input | DW | Data read from the memory |
| mem_ce_n | output | 1 | Chip enable, active low; low with high voltage is a program pulse |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_hv_en | output | 1 | Programming voltage enable |
| mem_vsel | output | 1 | Supply select: 1 high, 0 low |
| done | output | 1 | Job finished |
| fail | output | 1 | Job failed |
| fail_addr | output | AW | Address of the failing word |
| fail_phase | output | 2 | 0 programming, 1 high-supply check, 2 low-supply check |

## Verification
The bench uses a cell model in which each address needs a set number of pulses before it takes its data. It sets that count to exactly the pulse cap and to one more than the cap. A design off by one in the retry counter either fails a word that would have passed or applies a 26th pulse. It preloads partly written words, one compatible with the source and one not. A design missing the compatibility read would pulse a word it can never reach, or would refuse a word that only needs more zeros. It plants a cell that misreads only at one supply setting, so that swapped or merged check passes show up as the wrong fail_phase. It also fires a second start in the middle of a job, which a design that re-arms while busy would act on.

// File: rtl/otp_burn_ctrl.sv
module otp_burn_ctrl #(
  parameter int AW         = 20,
  parameter int DW         = 16,
  parameter int CLK_KHZ    = 125000,
  parameter int MAX_PULSES = 25,
  parameter int SU_NS      = 2000,
  parameter int HD_NS      = 2000,
  parameter int GAP_NS     = 2000,
  parameter int PW_NS      = 50000,
  parameter int ACC_NS     = 120
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] word_count,
  output logic [AW-1:0] src_idx,
  input  logic [DW-1:0] src_data,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wdata_oe,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_hv_en,
  output logic          mem_vsel,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [1:0]    fail_phase
);

  function automatic int ns2cyc(input int ns);
    longint v;
    v = (longint'(ns) * longint'(CLK_KHZ) + longint'(999999)) / longint'(1000000);
    return (v < 1) ? 1 : int'(v);
  endfunction

  localparam int T_SU  = ns2cyc(SU_NS);
  localparam int T_HD  = ns2cyc(HD_NS);
  localparam int T_GAP = ns2cyc(GAP_NS);
  localparam int T_PW  = ns2cyc(PW_NS);
  localparam int T_ACC = ns2cyc(ACC_NS);
  localparam int TW    = $clog2(T_SU + T_HD + T_GAP + T_PW + T_ACC + 1);
  localparam int CW    = $clog2(MAX_PULSES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ZERO, S_LOAD, S_PRE, S_SU, S_PW, S_HD, S_GAP, S_VER, S_NEXT, S_CLOAD, S_CRD
  } st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [CW-1:0] npul;
  logic [AW-1:0] idx, base_q, cnt_q, addr_q;
  logic [DW-1:0] wd;
  logic          chk_lo;

  logic [AW-1:0] idx_nx;
  logic          tdone, last;
  assign idx_nx = idx + 1'b1;
  assign tdone  = (tmr == '0);
  assign last   = (idx_nx == cnt_q);

  assign src_idx      = idx;
  assign mem_addr     = addr_q;
  assign mem_wdata    = wd;
  assign mem_ce_n     = !(st == S_PW || st == S_CRD);
  assign mem_oe_n     = !(st == S_PRE || st == S_VER || st == S_CRD);
  assign mem_wdata_oe = (st == S_SU || st == S_PW || st == S_HD);
  assign mem_hv_en    = (st == S_LOAD || st == S_PRE || st == S_SU || st == S_PW ||
                         st == S_HD || st == S_GAP || st == S_VER || st == S_NEXT);
  assign mem_vsel     = !chk_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      tmr        <= '0;
      npul       <= '0;
      idx        <= '0;
      base_q     <= '0;
      cnt_q      <= '0;
      addr_q     <= '0;
      wd         <= '0;
      chk_lo     <= 1'b0;
      done       <= 1'b0;
      fail       <= 1'b0;
      fail_addr  <= '0;
      fail_phase <= 2'd0;
    end else begin
      if (st != S_IDLE && st != S_ZERO && !tdone) tmr <= tmr - 1'b1;
      case (st)
        S_IDLE: if (start) begin
          done       <= 1'b0;
          fail       <= 1'b0;
          fail_addr  <= '0;
          fail_phase <= 2'd0;
          base_q     <= base_addr;
          cnt_q      <= word_count;
          idx        <= '0;
          chk_lo     <= 1'b0;
          st         <= (word_count == '0) ? S_ZERO : S_LOAD;
        end
        S_ZERO: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        S_LOAD: begin
          addr_q <= base_q + idx;
          wd     <= src_data;
          npul   <= '0;
          tmr    <= TW'(T_ACC - 1);
          st     <= S_PRE;
        end
        S_PRE: if (tdone) begin
          if ((wd & ~mem_rdata) != '0) begin
            done       <= 1'b1;
            fail       <= 1'b1;
            fail_addr  <= addr_q;
            fail_phase <= 2'd0;
            st         <= S_IDLE;
          end else begin
            tmr <= TW'(T_SU - 1);
            st  <= S_SU;
          end
        end
        S_SU: if (tdone) begin
          tmr <= TW'(T_PW - 1);
          st  <= S_PW;
        end
        S_PW: if (tdone) begin
          npul <= npul + 1'b1;
          tmr  <= TW'(T_HD - 1);
          st   <= S_HD;
        end
        S_HD: if (tdone) begin
          tmr <= TW'(T_GAP - 1);
          st  <= S_GAP;
        end
        S_GAP: if (tdone) begin
          tmr <= TW'(T_ACC - 1);
          st  <= S_VER;
        end
        S_VER: if (tdone) begin
          if (mem_rdata == wd) begin
            st <= S_NEXT;
          end else if (npul == CW'(MAX_PULSES)) begin
            done       <= 1'b1;
            fail       <= 1'b1;
            fail_addr  <= addr_q;
            fail_phase <= 2'd0;
            st         <= S_IDLE;
          end else begin
            tmr <= TW'(T_SU - 1);
            st  <= S_SU;
          end
        end
        S_NEXT: begin
          if (last) begin
            idx <= '0;
            st  <= S_CLOAD;
          end else begin
            idx <= idx_nx;
            st  <= S_LOAD;
          end
        end
        S_CLOAD: begin
          addr_q <= base_q + idx;
          wd     <= src_data;
          tmr    <= TW'(T_ACC - 1);
          st     <= S_CRD;
        end
        S_CRD: if (tdone) begin
          if (mem_rdata != wd) begin
            done       <= 1'b1;
            fail       <= 1'b1;
            fail_addr  <= addr_q;
            fail_phase <= chk_lo ? 2'd2 : 2'd1;
            chk_lo     <= 1'b0;
            st         <= S_IDLE;
          end else if (!last) begin
            idx <= idx_nx;
            st  <= S_CLOAD;
          end else if (!chk_lo) begin
            chk_lo <= 1'b1;
            idx    <= '0;
            st     <= S_CLOAD;
          end else begin
            chk_lo <= 1'b0;
            done   <= 1'b1;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/otp_burn_chk.sv
module otp_burn_chk #(
  parameter int AW         = 20,
  parameter int DW         = 16,
  parameter int CLK_KHZ    = 125000,
  parameter int MAX_PULSES = 25,
  parameter int SU_NS      = 2000,
  parameter int HD_NS      = 2000,
  parameter int GAP_NS     = 2000,
  parameter int PW_MIN_NS  = 45000,
  parameter int PW_MAX_NS  = 55000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_wdata_oe,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_hv_en,
  input logic          done,
  input logic          fail
);

  localparam longint KHZ   = longint'(CLK_KHZ);
  localparam int SU_C      = int'((longint'(SU_NS) * KHZ + 999999) / 1000000);
  localparam int HD_C      = int'((longint'(HD_NS) * KHZ + 999999) / 1000000);
  localparam int GAP_C     = int'((longint'(GAP_NS) * KHZ + 999999) / 1000000);
  localparam int PWMIN_C   = int'((longint'(PW_MIN_NS) * KHZ + 999999) / 1000000);
  localparam int PWMAX_C   = int'((longint'(PW_MAX_NS) * KHZ) / 1000000);

  logic [15:0]   c_drv, c_low, c_high;
  logic [7:0]    c_pul;
  logic [AW-1:0] a_prev;
  logic          ce_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_drv   <= '0;
      c_low   <= '0;
      c_high  <= 16'hFFFF;
      c_pul   <= '0;
      a_prev  <= '0;
      ce_prev <= 1'b1;
    end else begin
      ce_prev <= mem_ce_n;
      a_prev  <= mem_addr;
      c_drv   <= !mem_wdata_oe ? 16'd0 : (c_drv == 16'hFFFF ? c_drv : c_drv + 1'b1);
      c_low   <= mem_ce_n ? 16'd0 : (c_low == 16'hFFFF ? c_low : c_low + 1'b1);
      c_high  <= !mem_ce_n ? 16'd0 : (c_high == 16'hFFFF ? c_high : c_high + 1'b1);
      if (!mem_hv_en || mem_addr != a_prev) c_pul <= '0;
      else if (mem_ce_n && !ce_prev && c_pul != 8'hFF) c_pul <= c_pul + 1'b1;
    end
  end

  a_r3_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(c_pul) <= MAX_PULSES);

  a_r4_pulse_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && mem_hv_en) |-> mem_oe_n);

  a_r4_verify_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && mem_hv_en) |-> mem_ce_n);

  a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wdata_oe |-> mem_oe_n);

  a_r5_setup: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ce_n) && mem_hv_en) |-> int'(c_drv) >= SU_C);

  a_r5_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wdata_oe && $past(mem_wdata_oe)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

  a_r6_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_ce_n) && mem_hv_en) |-> (int'(c_low) >= PWMIN_C && int'(c_low) <= PWMAX_C));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_wdata_oe) && mem_hv_en) |-> int'(c_high) >= HD_C);

  a_r7_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_oe_n) && mem_hv_en) |-> int'(c_high) >= HD_C + GAP_C);

  a_r9_check_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !mem_hv_en) |-> (!mem_oe_n && !mem_wdata_oe));

  a_r10_fail_done: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);

  a_r10_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

endmodule

bind otp_burn_ctrl otp_burn_chk #(
  .AW(AW), .DW(DW), .CLK_KHZ(CLK_KHZ), .MAX_PULSES(MAX_PULSES),
  .SU_NS(SU_NS), .HD_NS(HD_NS), .GAP_NS(GAP_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_hv_en(mem_hv_en),
  .done(done), .fail(fail)
);

// File: tb/sim_otp_burn_ctrl.sv
module sim_otp_burn_ctrl;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int KHZ = 1000;
  localparam int E_SU = 2, E_HD = 2, E_GAP = 2, E_PW = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] base_addr = '0, word_count = '0;
  logic [AW-1:0] src_idx, mem_addr, fail_addr;
  logic [DW-1:0] src_data, mem_wdata, mem_rdata;
  logic mem_wdata_oe, mem_ce_n, mem_oe_n, mem_hv_en, mem_vsel, done, fail;
  logic [1:0] fail_phase;

  always #4 clk = ~clk;

  otp_burn_ctrl #(.AW(AW), .DW(DW), .CLK_KHZ(KHZ)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .word_count(word_count),
    .src_idx(src_idx), .src_data(src_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_hv_en(mem_hv_en), .mem_vsel(mem_vsel), .done(done),
    .fail(fail), .fail_addr(fail_addr), .fail_phase(fail_phase));

  logic [DW-1:0] mem [64];
  logic [DW-1:0] src [64];
  int pulses [64];
  int need [64];
  int weak_addr = -1;
  int weak_sel = 0;
  logic ce_q;

  assign src_data  = src[src_idx];
  assign mem_rdata = mem_oe_n ? 16'hFFFF :
    (mem[mem_addr] ^ ((int'(mem_addr) == weak_addr && !mem_hv_en && int'(mem_vsel) == weak_sel)
                      ? 16'h0001 : 16'h0000));

  always @(posedge clk) begin
    if (!rst_n) ce_q <= 1'b1;
    else begin
      ce_q <= mem_ce_n;
      if (mem_ce_n && !ce_q && mem_hv_en && mem_oe_n) begin
        pulses[mem_addr] <= pulses[mem_addr] + 1;
        if (pulses[mem_addr] + 1 >= need[mem_addr])
          mem[mem_addr] <= mem[mem_addr] & mem_wdata;
      end
    end
  end

  int nchk = 0, nbad = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct { bit f; int a; int ph; string tag; } exp_t;
  exp_t q[$];
  int npush = 0, nres = 0;
  logic done_q = 1'b0;

  int lowrun, hirun, surun;
  int pw_min, pw_max, su_min, hd_min, gap_min;
  bit bad_mode, any_strobe, saw_hi, saw_lo, order_bad;
  logic oe_q = 1'b1, drv_q = 1'b0, cen_q = 1'b1;

  task automatic clr_meas();
    pw_min = 1 << 30; pw_max = 0; su_min = 1 << 30; hd_min = 1 << 30; gap_min = 1 << 30;
    bad_mode = 0; any_strobe = 0; saw_hi = 0; saw_lo = 0; order_bad = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n || !mem_oe_n) any_strobe = 1;
      if (mem_hv_en && ((!mem_ce_n && !mem_oe_n) || !mem_vsel)) bad_mode = 1;
      if (mem_wdata_oe && !mem_oe_n) bad_mode = 1;
      if (!mem_ce_n && !mem_hv_en) begin
        if (mem_vsel) begin if (saw_lo) order_bad = 1; saw_hi = 1; end
        else saw_lo = 1;
      end
      if (mem_hv_en && !mem_ce_n && cen_q) su_min = (surun < su_min) ? surun : su_min;
      surun = (mem_wdata_oe && mem_ce_n) ? surun + 1 : (mem_wdata_oe ? surun : 0);
      if (mem_hv_en && !mem_ce_n) lowrun++;
      else if (lowrun > 0) begin
        pw_min = (lowrun < pw_min) ? lowrun : pw_min;
        pw_max = (lowrun > pw_max) ? lowrun : pw_max;
        lowrun = 0;
        hirun = 0;
      end
      if (mem_ce_n) begin
        if (mem_hv_en && drv_q && !mem_wdata_oe) hd_min = (hirun < hd_min) ? hirun : hd_min;
        if (mem_hv_en && oe_q && !mem_oe_n) gap_min = (hirun < gap_min) ? hirun : gap_min;
        hirun++;
      end
      oe_q = mem_oe_n; drv_q = mem_wdata_oe; cen_q = mem_ce_n;
      if (done && !done_q) begin
        exp_t e;
        if (q.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
        else begin
          e = q.pop_front();
          chk(fail == e.f, e.tag, "fail flag", fail, e.f);
          if (e.f) begin
            chk(int'(fail_addr) == e.a, e.tag, "fail_addr", fail_addr, e.a);
            chk(int'(fail_phase) == e.ph, e.tag, "fail_phase", fail_phase, e.ph);
          end
        end
        nres++;
      end
      done_q = done;
    end
  end

  task automatic run(input int base, input int cnt, input bit ef, input int ea,
                     input int eph, input string tag, input bit intrude);
    q.push_back('{f: ef, a: ea, ph: eph, tag: tag});
    npush++;
    clr_meas();
    lowrun = 0; hirun = 1 << 20; surun = 0;
    @(negedge clk);
    start = 1; base_addr = AW'(base); word_count = AW'(cnt);
    @(negedge clk);
    start = 0;
    if (intrude) begin
      repeat (30) @(negedge clk);
      start = 1; base_addr = 6'd56; word_count = 6'd1;
      @(negedge clk);
      start = 0;
    end
    while (nres != npush) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int psum();
    int s = 0;
    for (int i = 0; i < 64; i++) s += pulses[i];
    return s;
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
  end

  initial begin
    int s0;
    for (int i = 0; i < 64; i++) begin
      mem[i] = 16'hFFFF; src[i] = 16'h0000; pulses[i] = 0; need[i] = 1;
    end
    clr_meas();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(done == 0 && fail == 0, "R1", "done/fail after reset", {done, fail}, 0);
    chk(mem_ce_n && mem_oe_n, "R1", "ce_n/oe_n after reset", {mem_ce_n, mem_oe_n}, 3);
    chk(!mem_hv_en && !mem_wdata_oe, "R1", "hv/bus after reset", {mem_hv_en, mem_wdata_oe}, 0);

    // R2 basic block, timing measured on the way
    src[0] = 16'h1234; src[1] = 16'hABCD; src[2] = 16'h0000; src[3] = 16'hFFFE;
    run(4, 4, 0, 0, 0, "R2", 0);
    for (int i = 0; i < 4; i++) begin
      chk(mem[4+i] == src[i], "R2", "programmed word", mem[4+i], src[i]);
      chk(pulses[4+i] == 1, "R2", "pulse count", pulses[4+i], 1);
    end
    chk(!bad_mode, "R4", "strobe levels", bad_mode, 0);
    chk(su_min >= E_SU, "R5", "setup cycles", su_min, E_SU);
    chk(pw_min == E_PW && pw_max == E_PW, "R6", "pulse width", pw_min, E_PW);
    chk(hd_min >= E_HD, "R7", "data hold cycles", hd_min, E_HD);
    chk(gap_min >= E_HD + E_GAP, "R7", "pulse end to read", gap_min, E_HD + E_GAP);
    chk(saw_hi && saw_lo && !order_bad, "R9", "check pass order", {saw_hi, saw_lo, order_bad}, 6);
    chk(done && !fail, "R10", "pass status", {done, fail}, 2);

    // R3 retries up to and including the cap
    need[10] = 3; need[11] = 7; need[12] = 25;
    src[0] = 16'h5A5A; src[1] = 16'h0F0F; src[2] = 16'h8001;
    run(10, 3, 0, 0, 0, "R3", 0);
    chk(pulses[10] == 3, "R3", "pulses addr10", pulses[10], 3);
    chk(pulses[11] == 7, "R3", "pulses addr11", pulses[11], 7);
    chk(pulses[12] == 25, "R3", "pulses at cap", pulses[12], 25);
    chk(mem[12] == 16'h8001, "R2", "word at cap", mem[12], 16'h8001);

    // R3 cap exceeded
    need[21] = 26;
    src[0] = 16'h7777; src[1] = 16'h1111;
    run(20, 2, 1, 21, 0, "R3", 0);
    chk(pulses[21] == 25, "R3", "pulses on failing word", pulses[21], 25);
    chk(mem[21] == 16'hFFFF, "R3", "failing word unwritten", mem[21], 16'hFFFF);

    // R8 incompatible word
    mem[30] = 16'h00FF; src[0] = 16'h0F0F;
    run(30, 1, 1, 30, 0, "R8", 0);
    chk(pulses[30] == 0, "R8", "no pulse on refused word", pulses[30], 0);
    chk(mem[30] == 16'h00FF, "R8", "refused word untouched", mem[30], 16'h00FF);

    // R8 compatible partial word
    mem[31] = 16'hF0FF; src[0] = 16'h00F0;
    run(31, 1, 0, 0, 0, "R8", 0);
    chk(mem[31] == 16'h00F0, "R8", "partial word completed", mem[31], 16'h00F0);
    chk(pulses[31] == 1, "R8", "partial word pulses", pulses[31], 1);

    // R9 low-supply misread
    weak_addr = 41; weak_sel = 0;
    src[0] = 16'hC3C3; src[1] = 16'h3C3C;
    run(40, 2, 1, 41, 2, "R9", 0);
    // R9 high-supply misread
    weak_addr = 45; weak_sel = 1;
    src[0] = 16'h1111; src[1] = 16'h2222; src[2] = 16'h4444;
    run(44, 3, 1, 45, 1, "R9", 0);
    weak_addr = -1;

    // R11 empty job
    s0 = psum();
    run(60, 0, 0, 0, 0, "R11", 0);
    chk(!any_strobe, "R11", "no strobe on empty job", any_strobe, 0);
    chk(psum() == s0, "R11", "no pulses on empty job", psum(), s0);

    // R10 start while busy is ignored, status holds
    src[0] = 16'h0102; src[1] = 16'h0304;
    run(50, 2, 0, 0, 0, "R10", 1);
    chk(mem[56] == 16'hFFFF && pulses[56] == 0, "R10", "second start ignored", pulses[56], 0);
    chk(mem[51] == 16'h0304, "R10", "first job completed", mem[51], 16'h0304);
    repeat (20) @(negedge clk);
    chk(done && !fail, "R10", "status held", {done, fail}, 2);
    chk(q.size() == 0, "R10", "results outstanding", q.size(), 0);

    summary();
  end
endmodule